// File: doc/BRIEF.md
# Power Mode Clock Enable Controller

This block turns one master clock into clock-enable strobes for three consumers. The first is the core and memory domain. The second is a bank of peripherals. The third is a watchdog timer. Every strobe runs at half the master rate, because a phase bit toggles on every master cycle and an enable can only be high while that bit is set. No clock is gated. Downstream flops use the strobes as synchronous enables.

A three-state machine selects which domains are served:

- **RUN** (code 00) serves all domains.
- **WAIT** (code 01) holds the core strobe low and keeps the peripherals running.
- **STOP** (code 10) holds both the core and the peripheral strobes low.

The watchdog strobe keeps running in every state. The transitions are:

- **REQ_WAIT**: RUN to WAIT, on a request with code 01.
- **REQ_STOP**: RUN to STOP, on a request with code 10.
- **WAIT_WAKE**: WAIT to RUN, on a synchronous interrupt or a synchronized asynchronous interrupt.
- **STOP_WAKE**: STOP to RUN, on a synchronized bus-activity wake or a synchronized asynchronous interrupt.
- **RESET_RUN**: any state to RUN, on power-on, external or watchdog reset.

A STOP_WAKE caused by bus activity raises a one-cycle flag, because the message that woke the block is lost. A write port loads a per-peripheral enable register, and each bit of that register qualifies one peripheral strobe.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After power-on reset is released, `mode_o` is 00 (RUN) and every strobe is low until the first master edge. From that edge on, the strobes are served, and the enable register holds all ones.
- R2: `wdt_ce` is high on exactly one of every two master cycles, in every mode.
- R3: In RUN, `core_ce` and each `per_ce` bit whose register bit is set go high together with `wdt_ce`, once every two master cycles.
- R4: In WAIT (01), `core_ce` stays low while `per_ce` keeps the R3 pattern.
- R5: In STOP (10), `core_ce` and all of `per_ce` stay low.
- R6: A request (`req_vld` high with `req_code`) is acted on only in RUN, and the new mode is visible after the next edge. Code 01 selects WAIT and 10 selects STOP. Codes 00 and 11 leave RUN unchanged. A request made in WAIT or STOP is ignored.
- R7: In WAIT, `irq_pend` high at an edge returns the block to RUN at that edge. A pulse on `async_irq` returns it to RUN on the third edge after the pulse is sampled.
- R8: In STOP, `irq_pend` is ignored. A pulse on `can_wake` or `async_irq` returns the block to RUN on the third edge after the pulse is sampled, because of the two-flop synchronizer.
- R9: `can_msg_lost` is high for exactly the first RUN cycle after a STOP_WAKE caused by `can_wake`. It stays low after a wake caused by `async_irq`.
- R10: `en_wr` high at an edge loads `en_wdata` into the enable register, and the new value qualifies `per_ce` from that edge on. Bit i set to 0 holds `per_ce[i]` low.
- R11: `ext_rst` or `wdt_rst` high at an edge forces RUN and reloads the enable register with all ones at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst | input | 1 | External reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| req_vld | input | 1 | Mode request strobe |
| req_code | input | 2 | Requested mode: 00 RUN, 01 WAIT, 10 STOP |
| irq_pend | input | 1 | Unmasked synchronous interrupt |
| async_irq | input | 1 | Asynchronous interrupt wake |
| can_wake | input | 1 | Asynchronous bus-activity wake |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | NPER | Enable register write data |
| core_ce | output | 1 | Core and memory clock enable |
| per_ce | output | NPER | Per-peripheral clock enables |
| wdt_ce | output | 1 | Watchdog clock enable |
| mode_o | output | 2 | Current mode code |
| can_msg_lost | output | 1 | Lost-message flag for a bus-activity wake |

## Verification
The assertions check the following on every cycle:
- the watchdog and core strobes alternate;
- STOP keeps the core and peripheral strobes silent;
- WAIT never moves straight to STOP;
- STOP is only ever left for RUN;
- the lost-message flag lasts one cycle and appears only on a STOP-to-RUN step;
- a synchronous reset lands in RUN.

The directed scenarios are needed for the behaviour that depends on timing and on data:
- the exact edge at which a synchronized wake takes effect;
- that `irq_pend` cannot end STOP;
- that code 11 and requests made outside RUN are ignored;
- that the written enable pattern appears on `per_ce`;
- that a reset restores the pattern to all ones.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_WAIT = 2'b01,
        PM_STOP = 2'b10
    } pm_mode_e;

    localparam logic [1:0] CODE_WAIT = 2'b01;
    localparam logic [1:0] CODE_STOP = 2'b10;
endpackage

// File: rtl/pmc_sync.sv
// Multi-stage synchronizer for asynchronous wake inputs, one chain per bit.
module pmc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d_async[b]};
            end
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pmc_phase.sv
// Divide-by-two phase: high on every second master cycle.
module pmc_phase (
    input  logic clk,
    input  logic por_n,
    output logic ph_act
);
    logic ph_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    assign ph_act = ph_q;
endmodule

// File: rtl/pmc_fsm.sv
// Mode state machine: request entry, wake exit, lost-message flag.
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       soft_rst,
    input  logic       req_vld,
    input  logic [1:0] req_code,
    input  logic       irq_pend,
    input  logic       async_s,
    input  logic       can_s,
    output pm_mode_e   mode,
    output logic       lost
);
    pm_mode_e st_q, st_nxt;
    logic     lost_nxt;

    always_comb begin
        st_nxt   = st_q;
        lost_nxt = 1'b0;
        unique case (st_q)
            PM_RUN: begin
                if (req_vld) begin
                    if (req_code == CODE_WAIT) begin
                        st_nxt = PM_WAIT;
                    end else if (req_code == CODE_STOP) begin
                        st_nxt = PM_STOP;
                    end
                end
            end
            PM_WAIT: begin
                if (irq_pend || async_s) begin
                    st_nxt = PM_RUN;
                end
            end
            PM_STOP: begin
                if (can_s || async_s) begin
                    st_nxt   = PM_RUN;
                    lost_nxt = can_s;
                end
            end
            default: st_nxt = PM_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= PM_RUN;
        end else if (soft_rst) begin
            st_q <= PM_RUN;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lost <= 1'b0;
        end else if (soft_rst) begin
            lost <= 1'b0;
        end else begin
            lost <= lost_nxt;
        end
    end

    assign mode = st_q;
endmodule

// File: rtl/pmc_enreg.sv
// Per-peripheral enable register; resets to all ones.
module pmc_enreg #(
    parameter int NPER = 8
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            soft_rst,
    input  logic            wr,
    input  logic [NPER-1:0] wdata,
    output logic [NPER-1:0] en_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q <= '1;
        end else if (soft_rst) begin
            en_q <= '1;
        end else if (wr) begin
            en_q <= wdata;
        end
    end
endmodule

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl
    import pmc_pkg::*;
#(
    parameter int NPER        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            ext_rst,
    input  logic            wdt_rst,
    input  logic            req_vld,
    input  logic [1:0]      req_code,
    input  logic            irq_pend,
    input  logic            async_irq,
    input  logic            can_wake,
    input  logic            en_wr,
    input  logic [NPER-1:0] en_wdata,
    output logic            core_ce,
    output logic [NPER-1:0] per_ce,
    output logic            wdt_ce,
    output logic [1:0]      mode_o,
    output logic            can_msg_lost
);
    localparam int NWAKE = 2;

    logic             soft_rst;
    logic [NWAKE-1:0] wake_s;
    logic             ph_act;
    pm_mode_e         mode;
    logic [NPER-1:0]  en_q;
    logic             per_dom_on;

    assign soft_rst = ext_rst | wdt_rst;

    pmc_sync #(.W(NWAKE), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async ({can_wake, async_irq}),
        .q_sync  (wake_s)
    );

    pmc_phase u_phase (
        .clk    (clk),
        .por_n  (por_n),
        .ph_act (ph_act)
    );

    pmc_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .req_vld  (req_vld),
        .req_code (req_code),
        .irq_pend (irq_pend),
        .async_s  (wake_s[0]),
        .can_s    (wake_s[1]),
        .mode     (mode),
        .lost     (can_msg_lost)
    );

    pmc_enreg #(.NPER(NPER)) u_enreg (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .wr       (en_wr),
        .wdata    (en_wdata),
        .en_q     (en_q)
    );

    assign per_dom_on = ph_act && (mode != PM_STOP);
    assign core_ce    = ph_act && (mode == PM_RUN);
    assign wdt_ce     = ph_act;
    assign mode_o     = mode;

    for (genvar i = 0; i < NPER; i++) begin : g_per
        assign per_ce[i] = per_dom_on & en_q[i];
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int NPER = 8
) (
    input logic            clk,
    input logic            por_n,
    input logic            ext_rst,
    input logic            wdt_rst,
    input logic            core_ce,
    input logic [NPER-1:0] per_ce,
    input logic            wdt_ce,
    input logic [1:0]      mode_o,
    input logic            can_msg_lost
);
    p_wdt_off_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdt_ce |=> !wdt_ce);
    p_wdt_on_r2: assert property (@(posedge clk) disable iff (!por_n)
        !wdt_ce |=> wdt_ce);
    p_core_alt_r3: assert property (@(posedge clk) disable iff (!por_n)
        core_ce |=> !core_ce);
    p_wait_core_r4: assert property (@(posedge clk) disable iff (!por_n)
        (mode_o == 2'b01) |-> !core_ce);
    p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
        (mode_o == 2'b10) |-> (!core_ce && per_ce == '0));
    p_no_wait_to_stop_r6: assert property (@(posedge clk) disable iff (!por_n)
        (mode_o == 2'b01) |=> (mode_o != 2'b10));
    p_stop_exit_run_r8: assert property (@(posedge clk) disable iff (!por_n)
        (mode_o == 2'b10) |=> (mode_o == 2'b10 || mode_o == 2'b00));
    p_lost_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
        can_msg_lost |=> !can_msg_lost);
    p_lost_after_stop_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(can_msg_lost) |-> (mode_o == 2'b00 && $past(mode_o) == 2'b10));
    p_soft_rst_run_r11: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst || wdt_rst) |=> (mode_o == 2'b00 && !can_msg_lost));
endmodule

bind pwr_clk_ctl pmc_chk #(.NPER(NPER)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst      (ext_rst),
    .wdt_rst      (wdt_rst),
    .core_ce      (core_ce),
    .per_ce       (per_ce),
    .wdt_ce       (wdt_ce),
    .mode_o       (mode_o),
    .can_msg_lost (can_msg_lost)
);

// File: tb/sim_pwr_clk_ctl.sv
`timescale 1ns/1ps
module sim_pwr_clk_ctl;
    localparam int NPER = 8;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            ext_rst = 1'b0, wdt_rst = 1'b0;
    logic            req_vld = 1'b0;
    logic [1:0]      req_code = 2'b00;
    logic            irq_pend = 1'b0, async_irq = 1'b0, can_wake = 1'b0;
    logic            en_wr = 1'b0;
    logic [NPER-1:0] en_wdata = '0;
    logic            core_ce, wdt_ce, can_msg_lost;
    logic [NPER-1:0] per_ce;
    logic [1:0]      mode_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwr_clk_ctl #(.NPER(NPER)) u0 (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .req_vld(req_vld), .req_code(req_code), .irq_pend(irq_pend),
        .async_irq(async_irq), .can_wake(can_wake), .en_wr(en_wr),
        .en_wdata(en_wdata), .core_ce(core_ce), .per_ce(per_ce),
        .wdt_ce(wdt_ce), .mode_o(mode_o), .can_msg_lost(can_msg_lost)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_active();
        if (wdt_ce !== 1'b1) tick(1);
    endtask

    task automatic request(input logic [1:0] code);
        req_vld = 1'b1; req_code = code;
        tick(1);
        req_vld = 1'b0; req_code = 2'b00;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 2'b00);
        chk("R1 strobes low", {core_ce, wdt_ce, per_ce}, '0);
        tick(1);
        chk("R1 wdt first", wdt_ce, 1'b1);
        chk("R1 enables all ones", per_ce, {NPER{1'b1}});
        chk("R3 core first", core_ce, 1'b1);
    endtask

    task automatic t_run_pattern();
        int nc = 0, nw = 0, np = 0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            nc += core_ce; nw += wdt_ce; np += (per_ce == {NPER{1'b1}});
        end
        chk("R3 core count", nc, 4);
        chk("R3 per count", np, 4);
        chk("R2 wdt count run", nw, 4);
    endtask

    task automatic t_wait();
        int nc = 0, np = 0;
        request(2'b01);
        chk("R6 enter wait", mode_o, 2'b01);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            nc += core_ce; np += (per_ce == {NPER{1'b1}});
        end
        chk("R4 core silent", nc, 0);
        chk("R4 per active", np, 2);
        request(2'b10);
        chk("R6 stop ignored in wait", mode_o, 2'b01);
        irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
        chk("R7 irq wakes wait", mode_o, 2'b00);
    endtask

    task automatic t_wait_async();
        request(2'b01);
        async_irq = 1'b1; tick(1); async_irq = 1'b0;
        tick(1);
        chk("R7 async still wait after 2", mode_o, 2'b01);
        tick(1);
        chk("R7 async wakes wait", mode_o, 2'b00);
    endtask

    task automatic t_stop_can();
        int nw = 0, nq = 0;
        request(2'b10);
        chk("R6 enter stop", mode_o, 2'b10);
        irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
        chk("R8 irq ignored", mode_o, 2'b10);
        request(2'b00);
        chk("R6 run req ignored in stop", mode_o, 2'b10);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            nw += wdt_ce; nq += (core_ce | (|per_ce));
        end
        chk("R5 stop silent", nq, 0);
        chk("R2 wdt count stop", nw, 2);
        can_wake = 1'b1; tick(1); can_wake = 1'b0;
        tick(1);
        chk("R8 can still stop after 2", mode_o, 2'b10);
        tick(1);
        chk("R8 can wakes stop", mode_o, 2'b00);
        chk("R9 lost set", can_msg_lost, 1'b1);
        tick(1);
        chk("R9 lost one cycle", can_msg_lost, 1'b0);
    endtask

    task automatic t_stop_async();
        request(2'b10);
        async_irq = 1'b1; tick(1); async_irq = 1'b0;
        tick(2);
        chk("R8 async wakes stop", mode_o, 2'b00);
        chk("R9 no lost on async", can_msg_lost, 1'b0);
    endtask

    task automatic t_code11();
        request(2'b11);
        chk("R6 code 11 ignored", mode_o, 2'b00);
    endtask

    task automatic t_enreg();
        en_wr = 1'b1; en_wdata = 8'hA5; tick(1); en_wr = 1'b0;
        to_active();
        chk("R10 pattern", per_ce, 8'hA5);
        chk("R10 core unaffected", core_ce, 1'b1);
        en_wr = 1'b1; en_wdata = 8'h00; tick(1); en_wr = 1'b0;
        to_active();
        chk("R10 all off", per_ce, 8'h00);
    endtask

    task automatic t_soft_rst();
        request(2'b01);
        ext_rst = 1'b1; tick(1); ext_rst = 1'b0;
        chk("R11 ext rst run", mode_o, 2'b00);
        to_active();
        chk("R11 ext rst reg ones", per_ce, {NPER{1'b1}});
        en_wr = 1'b1; en_wdata = 8'h3C; tick(1); en_wr = 1'b0;
        request(2'b10);
        wdt_rst = 1'b1; tick(1); wdt_rst = 1'b0;
        chk("R11 wdt rst run", mode_o, 2'b00);
        to_active();
        chk("R11 wdt rst reg ones", per_ce, {NPER{1'b1}});
    endtask

    initial begin
        #200_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(2);
        por_n = 1'b1;
        t_reset();
        t_run_pattern();
        t_wait();
        t_wait_async();
        t_stop_can();
        t_stop_async();
        t_code11();
        t_enreg();
        t_soft_rst();
        tick(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule